// File: doc/BRIEF.md
# Pixel Write Request Bridge

This block moves single-pixel writes from a slow host register into an on-chip frame memory. The host presents one request word that packs a request flag, a pixel value and a row/column address. The bridge brings the word into its own clock domain through a synchronizer and commits exactly one memory write. It then raises an acknowledge. The acknowledge stays up until the host has cleared the whole word to zero.

The handshake has four phases: the host raises the request, the bridge acknowledges, the host clears the word, and the bridge drops the acknowledge. A request held for any number of cycles therefore yields one write only. Fields that change while the request stays high are ignored.

The frame memory is an inferred array covering a parameterised window of the row/column space. Its combinational read port lets the contents be checked. Writes that fall outside the window are acknowledged but not stored, and reads outside the window return zero.

Top module: `pix_wr_bridge`

## Requirements
- R1: The request word is 22 bits: bit 21 is the request flag, bits 20:18 the pixel, bits 17:9 the row, bits 8:0 the column. A word with bit 21 low starts no write, whatever its other bits hold.
- R2: While the write strobe is high, `wr_addr_o` equals {row, column} with the row in the upper 9 bits, and `wr_data_o` equals the pixel.
- R3: Each held request produces exactly one write strobe, one clock cycle long, however long the request is held.
- R4: The strobe is high in the cycle after the third rising edge that samples a newly applied request word. The acknowledge rises on the fourth such edge.
- R5: The acknowledge stays high for as long as the request flag stays high.
- R6: The acknowledge falls on the third rising edge that samples the cleared word. The acknowledge and the strobe are never high together.
- R7: Once the acknowledge has returned low, reapplying an identical request produces a new write.
- R8: A write to row < 32 and column < 64 stores the pixel. The read port returns it once the acknowledge is high. Out-of-window writes leave the memory unchanged, and out-of-window reads return 0.
- R9: During reset, the acknowledge, strobe, write address and write data outputs are all zero.
- R10: Changes to the pixel, row or column while the request stays high cause no further write. The memory at the changed address keeps its old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_word_i | input | 22 | Host request word (flag, pixel, row, column) |
| ack_o | output | 1 | Write committed acknowledge |
| wr_strobe_o | output | 1 | One-cycle memory write strobe |
| wr_addr_o | output | 18 | Write address {row, column} |
| wr_data_o | output | 3 | Write pixel value |
| rd_row_i | input | 9 | Read port row |
| rd_col_i | input | 9 | Read port column |
| rd_data_o | output | 3 | Read port pixel (0 outside the window) |

## Verification
A request word applied between edges passes two synchronizer registers and the control register. The strobe is therefore due after the third rising edge, and the acknowledge and the stored pixel after the fourth. Clearing the word takes the same three edges to pull the acknowledge low. The bench drives and samples only on falling edges and counts exactly that many edges before each comparison. Strobe pulses are tallied on every rising edge, so a duplicate or missing write is caught whatever the hold time.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int unsigned ROW_W_DEF = 9;
  localparam int unsigned COL_W_DEF = 9;
  localparam int unsigned PIX_W_DEF = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_ACK   = 2'd2
  } bridge_state_e;
endpackage

// File: rtl/pwb_sync.sv
module pwb_sync #(
  parameter int unsigned WIDTH  = 22,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int unsigned ROW_W = ROW_W_DEF,
  parameter int unsigned COL_W = COL_W_DEF,
  parameter int unsigned PIX_W = PIX_W_DEF
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [PIX_W+ROW_W+COL_W:0] req_word_i,
  output logic                      wr_en_o,
  output logic [ROW_W+COL_W-1:0]    wr_addr_o,
  output logic [PIX_W-1:0]          wr_data_o,
  output logic                      ack_o
);
  localparam int unsigned ADDR_W  = ROW_W + COL_W;
  localparam int unsigned REQ_BIT = PIX_W + ADDR_W;

  bridge_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [PIX_W-1:0]  data_q;
  logic              req_bit;
  logic [PIX_W-1:0]  pix_f;
  logic [ROW_W-1:0]  row_f;
  logic [COL_W-1:0]  col_f;
  logic              accept;

  assign req_bit = req_word_i[REQ_BIT];
  assign pix_f   = req_word_i[REQ_BIT-1 -: PIX_W];
  assign row_f   = req_word_i[COL_W +: ROW_W];
  assign col_f   = req_word_i[COL_W-1:0];
  assign accept  = (state_q == ST_IDLE) && req_bit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_bit) state_d = ST_WRITE;
      ST_WRITE: state_d = ST_ACK;
      ST_ACK:   if (!req_bit) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q <= {row_f, col_f};
        data_q <= pix_f;
      end
    end
  end

  assign wr_en_o   = (state_q == ST_WRITE);
  assign ack_o     = (state_q == ST_ACK);
  assign wr_addr_o = addr_q;
  assign wr_data_o = data_q;

  // R3: strobe never lasts two cycles
  a_r3_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);
  // R4: committed write is acknowledged next cycle
  a_r4_ack_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> ack_o);
  // R5
  a_r5_ack_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && req_bit) |=> ack_o);
  // R6
  a_r6_ack_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !req_bit) |=> !ack_o);
  a_r6_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_o && wr_en_o));
  // R7: a write is only started from a released handshake
  a_r7_accept_after_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(!ack_o));
  // R10: captured fields frozen while acknowledged
  a_r10_fields_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ($stable(wr_addr_o) && $stable(wr_data_o)));
endmodule

// File: rtl/pwb_fmem.sv
module pwb_fmem #(
  parameter int unsigned PIX_W        = 3,
  parameter int unsigned ROW_W        = 9,
  parameter int unsigned COL_W        = 9,
  parameter int unsigned WIN_ROW_BITS = 5,
  parameter int unsigned WIN_COL_BITS = 6
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [ROW_W-1:0] wr_row_i,
  input  logic [COL_W-1:0] wr_col_i,
  input  logic [PIX_W-1:0] wr_data_i,
  input  logic [ROW_W-1:0] rd_row_i,
  input  logic [COL_W-1:0] rd_col_i,
  output logic [PIX_W-1:0] rd_data_o
);
  localparam int unsigned RB    = (WIN_ROW_BITS < ROW_W) ? WIN_ROW_BITS : ROW_W;
  localparam int unsigned CB    = (WIN_COL_BITS < COL_W) ? WIN_COL_BITS : COL_W;
  localparam int unsigned IDX_W = RB + CB;
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [PIX_W-1:0] cells_q [DEPTH];
  logic             wr_row_ok, wr_col_ok, rd_row_ok, rd_col_ok;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  if (RB < ROW_W) begin : g_row_clip
    assign wr_row_ok = ~|wr_row_i[ROW_W-1:RB];
    assign rd_row_ok = ~|rd_row_i[ROW_W-1:RB];
  end else begin : g_row_full
    assign wr_row_ok = 1'b1;
    assign rd_row_ok = 1'b1;
  end

  if (CB < COL_W) begin : g_col_clip
    assign wr_col_ok = ~|wr_col_i[COL_W-1:CB];
    assign rd_col_ok = ~|rd_col_i[COL_W-1:CB];
  end else begin : g_col_full
    assign wr_col_ok = 1'b1;
    assign rd_col_ok = 1'b1;
  end

  assign wr_idx = {wr_row_i[RB-1:0], wr_col_i[CB-1:0]};
  assign rd_idx = {rd_row_i[RB-1:0], rd_col_i[CB-1:0]};

  always_ff @(posedge clk_i) begin
    if (wr_en_i && wr_row_ok && wr_col_ok) cells_q[wr_idx] <= wr_data_i;
  end

  assign rd_data_o = (rd_row_ok && rd_col_ok) ? cells_q[rd_idx] : '0;
endmodule

// File: rtl/pix_wr_bridge.sv
module pix_wr_bridge
  import pwb_pkg::*;
#(
  parameter int unsigned ROW_W        = ROW_W_DEF,
  parameter int unsigned COL_W        = COL_W_DEF,
  parameter int unsigned PIX_W        = PIX_W_DEF,
  parameter int unsigned WIN_ROW_BITS = 5,
  parameter int unsigned WIN_COL_BITS = 6,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [PIX_W+ROW_W+COL_W:0] req_word_i,
  output logic                       ack_o,
  output logic                       wr_strobe_o,
  output logic [ROW_W+COL_W-1:0]     wr_addr_o,
  output logic [PIX_W-1:0]           wr_data_o,
  input  logic [ROW_W-1:0]           rd_row_i,
  input  logic [COL_W-1:0]           rd_col_i,
  output logic [PIX_W-1:0]           rd_data_o
);
  localparam int unsigned ADDR_W = ROW_W + COL_W;
  localparam int unsigned WORD_W = PIX_W + ADDR_W + 1;

  logic [WORD_W-1:0] req_sync;

  pwb_sync #(
    .WIDTH  (WORD_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (req_word_i),
    .q_o    (req_sync)
  );

  pwb_ctrl #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .PIX_W (PIX_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_word_i (req_sync),
    .wr_en_o    (wr_strobe_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .ack_o      (ack_o)
  );

  pwb_fmem #(
    .PIX_W        (PIX_W),
    .ROW_W        (ROW_W),
    .COL_W        (COL_W),
    .WIN_ROW_BITS (WIN_ROW_BITS),
    .WIN_COL_BITS (WIN_COL_BITS)
  ) u_fmem (
    .clk_i     (clk_i),
    .wr_en_i   (wr_strobe_o),
    .wr_row_i  (wr_addr_o[ADDR_W-1:COL_W]),
    .wr_col_i  (wr_addr_o[COL_W-1:0]),
    .wr_data_i (wr_data_o),
    .rd_row_i  (rd_row_i),
    .rd_col_i  (rd_col_i),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: tb/pix_wr_bridge_bench.sv
`timescale 1ns/1ps
module pix_wr_bridge_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [21:0] req_word_i = '0;
  logic        ack_o, wr_strobe_o;
  logic [17:0] wr_addr_o;
  logic [2:0]  wr_data_o;
  logic [8:0]  rd_row_i = '0;
  logic [8:0]  rd_col_i = '0;
  logic [2:0]  rd_data_o;

  int vectors = 0;
  int miscompares = 0;
  int strobe_cnt = 0;
  bit done = 1'b0;

  logic [2:0] model [2048];
  bit         known [2048];

  pix_wr_bridge u_pix_wr_bridge (
    .clk_i, .rst_ni, .req_word_i, .ack_o, .wr_strobe_o,
    .wr_addr_o, .wr_data_o, .rd_row_i, .rd_col_i, .rd_data_o
  );

  always #4 clk_i = ~clk_i;

  always @(posedge clk_i) if (rst_ni && wr_strobe_o) strobe_cnt++;

  function automatic logic [21:0] mk_word(int r, int c, int p);
    return {1'b1, p[2:0], r[8:0], c[8:0]};
  endfunction

  function automatic bit in_win(int r, int c);
    return (r < 32) && (c < 64);
  endfunction

  function automatic int cidx(int r, int c);
    return r * 64 + c;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_cell(string req, int r, int c);
    @(negedge clk_i);
    rd_row_i = r[8:0];
    rd_col_i = c[8:0];
    #1;
    if (!in_win(r, c)) chk(req, "read outside window", {29'd0, rd_data_o}, 32'd0);
    else if (known[cidx(r, c)]) chk(req, "read cell", {29'd0, rd_data_o}, {29'd0, model[cidx(r, c)]});
  endtask

  // full four-phase transaction; alt != 0 replaces the word during the hold
  task automatic do_write(int r, int c, int p, int hold, logic [21:0] alt);
    int base;
    base = strobe_cnt;
    @(negedge clk_i);
    req_word_i = mk_word(r, c, p);
    rd_row_i = r[8:0];
    rd_col_i = c[8:0];
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R4", "strobe early", {31'd0, wr_strobe_o}, 32'd0);
    @(negedge clk_i);
    chk("R4", "strobe due", {31'd0, wr_strobe_o}, 32'd1);
    chk("R2", "write address", {14'd0, wr_addr_o}, {14'd0, r[8:0], c[8:0]});
    chk("R2", "write data", {29'd0, wr_data_o}, {29'd0, p[2:0]});
    chk("R6", "ack during strobe", {31'd0, ack_o}, 32'd0);
    @(negedge clk_i);
    chk("R3", "strobe width", {31'd0, wr_strobe_o}, 32'd0);
    chk("R4", "ack due", {31'd0, ack_o}, 32'd1);
    if (in_win(r, c)) begin
      model[cidx(r, c)] = p[2:0];
      known[cidx(r, c)] = 1'b1;
      chk("R8", "stored pixel", {29'd0, rd_data_o}, {29'd0, p[2:0]});
    end else begin
      chk("R8", "outside window read", {29'd0, rd_data_o}, 32'd0);
    end
    for (int i = 0; i < hold; i++) begin
      if (alt != '0) req_word_i = alt;
      @(negedge clk_i);
      chk("R5", "ack held", {31'd0, ack_o}, 32'd1);
      chk("R3", "no repeat strobe", {31'd0, wr_strobe_o}, 32'd0);
    end
    req_word_i = '0;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R6", "ack before release", {31'd0, ack_o}, 32'd1);
    @(negedge clk_i);
    chk("R6", "ack released", {31'd0, ack_o}, 32'd0);
    chk("R3", "one write per request", strobe_cnt - base, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      miscompares++;
      $display("FAIL R4 watchdog expired: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0BAD_F00D));
    for (int i = 0; i < 2048; i++) known[i] = 1'b0;
    rd_row_i = 9'd100;
    repeat (3) @(negedge clk_i);
    chk("R9", "reset ack", {31'd0, ack_o}, 32'd0);
    chk("R9", "reset strobe", {31'd0, wr_strobe_o}, 32'd0);
    chk("R9", "reset addr", {14'd0, wr_addr_o}, 32'd0);
    chk("R9", "reset data", {29'd0, wr_data_o}, 32'd0);
    chk("R8", "reset read outside window", {29'd0, rd_data_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: flag low, fields set -> nothing happens
    begin
      int base;
      base = strobe_cnt;
      req_word_i = {1'b0, 3'd5, 9'd3, 9'd4};
      repeat (6) @(negedge clk_i);
      chk("R1", "no strobe without flag", strobe_cnt - base, 32'd0);
      chk("R1", "no ack without flag", {31'd0, ack_o}, 32'd0);
      req_word_i = '0;
      repeat (3) @(negedge clk_i);
    end

    // directed corners
    do_write(0, 0, 5, 0, '0);
    do_write(31, 63, 2, 2, '0);
    do_write(511, 511, 7, 1, '0);             // R8 outside window
    chk_cell("R8", 31, 63);
    do_write(32, 0, 6, 0, '0);                // R8 row just outside
    chk_cell("R8", 0, 0);
    do_write(0, 0, 5, 30, '0);                // R3 long hold
    do_write(0, 0, 5, 0, '0);                 // R7 identical request again

    // R10: change fields while held
    do_write(6, 7, 1, 0, '0);
    do_write(4, 5, 3, 4, mk_word(6, 7, 6));
    chk_cell("R10", 6, 7);
    chk_cell("R10", 4, 5);

    // constrained random
    for (int n = 0; n < 60; n++) begin
      int r, c, p, h;
      r = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 511)) : int'($urandom_range(0, 31));
      c = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 511)) : int'($urandom_range(0, 63));
      p = int'($urandom_range(0, 7));
      h = int'($urandom_range(0, 5));
      do_write(r, c, p, h, '0);
    end

    // read-back sweep of every cell the model knows
    for (int i = 0; i < 2048; i++) begin
      if (known[i]) chk_cell("R8", i / 64, i % 64);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule